// File: doc/BRIEF.md
# Peripheral IO Space Access Decoder

This block sits between a 68000-style CPU bus and the peripheral register window that occupies the top 32 KiB of a 24-bit address space (0xFF8000 to 0xFFFFFF). It accepts one byte, word or long access per cycle. It splits the access into up to four byte lanes and sorts each lane into one of four kinds: a live register, a hole that faults, a void byte that reads 0xFF, or a void byte that reads 0x00. It then answers one cycle later with a bus-error flag or with assembled read data. For every distinct register the access touches, it raises one strobe carrying a register index.

A bus error needs every byte of the access to land in a hole. An access that only partly overlaps a real register therefore completes. On machines without the extended bus, the sound-chip window is mirrored across 0xFF8804 to 0xFF88FF. Configuration inputs remove the optional blitter and real-time clock. A bus-mode bit kept inside the block chooses how the mirror range decodes on extended-bus machines. Peripherals supply read bytes on a per-lane input in the request cycle and take write bytes from a per-lane output.

Top module: `io_space_decoder`

## Requirements
- R1: Only `req_addr[23:0]` is decoded; the upper bits are ignored. Any access whose 24-bit address is below 0xFF8000 answers with `rsp_berr`=1, no strobes, and, on a read, `rsp_rdata`=0xFFFFFFFF.
- R2: A write with `req_super`=0 answers with `rsp_berr`=1 and no strobes. Reads behave identically for either value of `req_super`.
- R3: A word access at 0xFFFFFF, or a long access above 0xFFFFFC, is rejected. It answers with `rsp_berr`=0 and no strobes. A rejected read returns 0xFFFFFFFF. R1 and R2 take precedence over this rule.
- R4: An access faults only when every lane it covers is a hole: one lane for `req_size`=0 (byte), two for 1 (word), four for 2 or 3 (long). A hole lane in a read that does not fault returns 0xFF. A faulting access raises no strobes.
- R5: A void-FF lane reads 0xFF and a void-00 lane reads 0x00. Neither kind ever raises a strobe, so writes to it are ignored.
- R6: Lane i covers address base+i. It strobes (`lane_stb[i]`) only if it is a register lane, the access is neither faulting nor rejected, and lane i-1 is not the same register. `lane_idx[15*i +: 15]` is the offset from 0xFF8000 of the register's first byte.
- R7: Read data is big-endian and right-aligned. A byte read places lane 0 in bits 7:0. A word read places lane 0 in 15:8 and lane 1 in 7:0. A long read places lane 0 in 31:24 through lane 3 in 7:0. Unused upper bits are 0, and every write returns 0.
- R8: With `cfg_ext_bus`=0, addresses 0xFF8804 to 0xFF88FF decode as the address ANDed with 0xFFF803.
- R9: With `cfg_blitter_on`=0, 0xFF8A00 to 0xFF8A3F are holes.
- R10: With `cfg_rtc_on`=0, 0xFFFC21 to 0xFFFC3F are void-FF.
- R11: With `cfg_ext_bus`=1, an accepted write that strobes the register at offset 7 (0xFF8007) loads bit 5 of that lane's byte into the bus-mode bit, which resets to 0. The new value takes effect from the next request. When the bit is 0, the mirror range is void-FF; when it is 1, the mirror range is holes.
- R12: Every output is registered. `rsp_valid` pulses in the cycle after each request, and all outputs are 0 in cycles without a response. `rsp_write` echoes the request direction. `lane_wdata[8*i +: 8]` holds lane i's write byte, taken from `req_wdata` with the same alignment as R7, and is 0 for lanes the access does not cover.
- R13: The region map is as follows. Anything not listed is a hole.
  - 0xFF8000 to 0xFF803F: byte registers.
  - 0xFF8200 to 0xFF823F: odd bytes are byte registers and even bytes are holes.
  - 0xFF8240 to 0xFF827F: two-byte registers at even addresses.
  - 0xFF8280 to 0xFF82FF: void-00.
  - 0xFF8800 to 0xFF8803: two two-byte registers, at 0xFF8800 and 0xFF8802.
  - 0xFF8A00 to 0xFF8A3F: two-byte registers.
  - 0xFFFA00 to 0xFFFA3F: odd bytes are registers and even bytes are void-FF.
  - 0xFFFC00 to 0xFFFC07: byte registers.
  - 0xFFFC21 to 0xFFFC3F: odd bytes are registers and even bytes are holes. 0xFFFC20 is always a hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_addr | input | 32 | Byte address; only bits 23:0 are decoded |
| req_super | input | 1 | CPU supervisor mode |
| req_wdata | input | 32 | Right-aligned write data |
| lane_rdata | input | 32 | Peripheral read byte for lane i in bits 8i+7:8i |
| cfg_blitter_on | input | 1 | Blitter present |
| cfg_rtc_on | input | 1 | Real-time clock present |
| cfg_ext_bus | input | 1 | Machine has the extended bus |
| rsp_valid | output | 1 | Response pulse |
| rsp_berr | output | 1 | Bus error |
| rsp_write | output | 1 | Direction of the answered request |
| rsp_rdata | output | 32 | Assembled read data |
| lane_stb | output | 4 | Register strobe per lane |
| lane_idx | output | 60 | 15-bit register offset per lane |
| lane_wdata | output | 32 | Write byte per lane |

## Verification
The assertions rely on two properties of the inputs. First, a request is held for exactly the cycle in which it is presented. Second, `req_addr` and `req_size` are known whenever `req_valid` is high, so the internal window, mode and span flags are well defined at each sampled edge. The stimulus meets these conditions by driving each request on a falling edge and dropping `req_valid` on the following falling edge. Configuration inputs change only between requests, and `lane_rdata` is set together with the address it answers.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W = 24;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int IDX_W  = 15;
  localparam logic [ADDR_W-1:0] WIN_BASE = 24'hFF8000;
  localparam logic [ADDR_W-1:0] MIR_LO   = 24'hFF8804;
  localparam logic [ADDR_W-1:0] MIR_HI   = 24'hFF88FF;
  localparam logic [ADDR_W-1:0] MIR_MASK = 24'hFFF803;
  localparam logic [IDX_W-1:0]  MODE_REG_IDX = 15'h0007;
  localparam int MODE_BIT = 5;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  typedef enum logic [1:0] {
    K_HOLE    = 2'd0,
    K_REG     = 2'd1,
    K_VOID_FF = 2'd2,
    K_VOID_00 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    MIR_SHADOW = 2'd0,
    MIR_VOID   = 2'd1,
    MIR_HOLE   = 2'd2
  } mirror_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
  } lane_cls_t;

  // Number of lanes an access covers (R4)
  function automatic int lane_count(input logic [1:0] size);
    if (size == SZ_BYTE) return 1;
    if (size == SZ_WORD) return 2;
    return LANES;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size);
    int m;
    m = (1 << lane_count(size)) - 1;
    return LANES'(m);
  endfunction

  // Last byte of the access runs past the 24-bit space (R3)
  function automatic logic span_overruns(input logic [ADDR_W-1:0] a, input logic [1:0] size);
    logic [ADDR_W:0] last;
    last = {1'b0, a} + (ADDR_W+1)'(lane_count(size) - 1);
    return last[ADDR_W];
  endfunction

  function automatic logic [IDX_W-1:0] offs(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] offs_even(input logic [ADDR_W-1:0] a);
    return {a[IDX_W-1:1], 1'b0};
  endfunction

  // Region map with mirror, blitter and clock variants (R8, R9, R10, R13)
  function automatic lane_cls_t classify(input logic [ADDR_W-1:0] a,
                                         input logic blit_on,
                                         input logic rtc_on,
                                         input mirror_e mm);
    lane_cls_t c;
    logic [ADDR_W-1:0] f;
    logic in_mir;
    c.kind = K_HOLE;
    c.idx  = '0;
    in_mir = (a >= MIR_LO) && (a <= MIR_HI);
    f = (in_mir && mm == MIR_SHADOW) ? (a & MIR_MASK) : a;
    if (in_mir && mm != MIR_SHADOW) begin
      c.kind = (mm == MIR_VOID) ? K_VOID_FF : K_HOLE;
    end else if (f inside {[24'hFF8000:24'hFF803F]}) begin
      c.kind = K_REG; c.idx = offs(f);
    end else if (f inside {[24'hFF8200:24'hFF823F]}) begin
      if (f[0]) begin c.kind = K_REG; c.idx = offs(f); end
    end else if (f inside {[24'hFF8240:24'hFF827F]}) begin
      c.kind = K_REG; c.idx = offs_even(f);
    end else if (f inside {[24'hFF8280:24'hFF82FF]}) begin
      c.kind = K_VOID_00;
    end else if (f inside {[24'hFF8800:24'hFF8803]}) begin
      c.kind = K_REG; c.idx = offs_even(f);
    end else if (f inside {[24'hFF8A00:24'hFF8A3F]}) begin
      if (blit_on) begin c.kind = K_REG; c.idx = offs_even(f); end
    end else if (f inside {[24'hFFFA00:24'hFFFA3F]}) begin
      if (f[0]) begin c.kind = K_REG; c.idx = offs(f); end
      else c.kind = K_VOID_FF;
    end else if (f inside {[24'hFFFC00:24'hFFFC07]}) begin
      c.kind = K_REG; c.idx = offs(f);
    end else if (f inside {[24'hFFFC21:24'hFFFC3F]}) begin
      if (!rtc_on) c.kind = K_VOID_FF;
      else if (f[0]) begin c.kind = K_REG; c.idx = offs(f); end
    end
    return c;
  endfunction
endpackage

// File: rtl/io_lane_class.sv
module io_lane_class
  import io_dec_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              blit_on,
  input  logic              rtc_on,
  input  mirror_e           mir_mode,
  output lane_cls_t         cls
);
  logic [ADDR_W-1:0] lane_addr;

  assign lane_addr = base_addr + ADDR_W'(LANE);
  assign cls       = classify(lane_addr, blit_on, rtc_on, mir_mode);
endmodule

// File: rtl/io_strobe_merge.sv
module io_strobe_merge
  import io_dec_pkg::*;
(
  input  lane_cls_t [LANES-1:0] cls,
  input  logic [LANES-1:0]      lane_en,
  input  logic                  go,
  output logic [LANES-1:0]      stb,
  output logic [LANES-1:0]      hole
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic is_reg;
    assign is_reg  = lane_en[i] && (cls[i].kind == K_REG);
    assign hole[i] = lane_en[i] && (cls[i].kind == K_HOLE);
    if (i == 0) begin : g_first
      assign stb[i] = go && is_reg;
    end else begin : g_rest
      // one strobe per register: suppress when the previous lane hit it (R6)
      logic same_as_prev;
      assign same_as_prev = (cls[i-1].kind == K_REG) && (cls[i-1].idx == cls[i].idx);
      assign stb[i] = go && is_reg && !same_as_prev;
    end
  end
endmodule

// File: rtl/io_lane_align.sv
module io_lane_align
  import io_dec_pkg::*;
(
  input  logic [1:0]            size,
  input  lane_cls_t [LANES-1:0] cls,
  input  logic [DATA_W-1:0]     lane_rdata,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [DATA_W-1:0]     rd_packed,
  output logic [DATA_W-1:0]     wr_lanes
);
  logic [BYTE_W-1:0] lb [LANES];

  // per-lane read byte by kind (R4, R5)
  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign lb[i] = (cls[i].kind == K_REG)     ? lane_rdata[i*BYTE_W +: BYTE_W] :
                   (cls[i].kind == K_VOID_00) ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}};
  end

  // big-endian packing and unpacking (R7, R12)
  always_comb begin
    int n;
    n = lane_count(size);
    rd_packed = '0;
    wr_lanes  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) begin
        rd_packed = {rd_packed[DATA_W-BYTE_W-1:0], lb[i]};
        wr_lanes[i*BYTE_W +: BYTE_W] = req_wdata[(n-1-i)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/io_space_decoder.sv
module io_space_decoder
  import io_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_addr,
  input  logic                    req_super,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W-1:0]       lane_rdata,
  input  logic                    cfg_blitter_on,
  input  logic                    cfg_rtc_on,
  input  logic                    cfg_ext_bus,
  output logic                    rsp_valid,
  output logic                    rsp_berr,
  output logic                    rsp_write,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [LANES-1:0]        lane_stb,
  output logic [LANES*IDX_W-1:0]  lane_idx,
  output logic [DATA_W-1:0]       lane_wdata
);
  logic [ADDR_W-1:0] a24;
  logic              mode_q;
  mirror_e           mir_mode;
  lane_cls_t [LANES-1:0] cls;
  logic [LANES-1:0]  lane_en, stb_c, hole_c;
  logic [DATA_W-1:0] rd_c, wd_c;
  logic out_of_window, user_write_fault, early_fault, bad_span, go, all_holes, fault;
  logic hit_mode_reg, mode_wr_val;

  assign a24 = req_addr[ADDR_W-1:0];   // R1

  // bus-mode bit picks how the mirror range decodes (R8, R11)
  assign mir_mode = !cfg_ext_bus ? MIR_SHADOW : (mode_q ? MIR_HOLE : MIR_VOID);

  for (genvar i = 0; i < LANES; i++) begin : g_cls
    io_lane_class #(.LANE(i)) u_cls (
      .base_addr (a24),
      .blit_on   (cfg_blitter_on),
      .rtc_on    (cfg_rtc_on),
      .mir_mode  (mir_mode),
      .cls       (cls[i])
    );
  end

  assign lane_en          = lane_mask(req_size);
  assign out_of_window    = a24 < WIN_BASE;                 // R1
  assign user_write_fault = req_write && !req_super;        // R2
  assign early_fault      = out_of_window || user_write_fault;
  assign bad_span         = span_overruns(a24, req_size);   // R3
  assign go               = !early_fault && !bad_span;

  io_strobe_merge u_merge (
    .cls     (cls),
    .lane_en (lane_en),
    .go      (go),
    .stb     (stb_c),
    .hole    (hole_c)
  );

  assign all_holes = (hole_c == lane_en);                   // R4
  assign fault     = early_fault || (go && all_holes);

  io_lane_align u_align (
    .size       (req_size),
    .cls        (cls),
    .lane_rdata (lane_rdata),
    .req_wdata  (req_wdata),
    .rd_packed  (rd_c),
    .wr_lanes   (wd_c)
  );

  // write to the bus-mode register (R11)
  always_comb begin
    hit_mode_reg = 1'b0;
    mode_wr_val  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (stb_c[i] && cls[i].idx == MODE_REG_IDX) begin
        hit_mode_reg = 1'b1;
        mode_wr_val  = wd_c[i*BYTE_W + MODE_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (req_valid && req_write && cfg_ext_bus && hit_mode_reg) mode_q <= mode_wr_val;
  end

  // registered one-cycle response (R12)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_berr   <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_rdata  <= '0;
      lane_stb   <= '0;
      lane_idx   <= '0;
      lane_wdata <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_berr   <= req_valid && fault;
      rsp_write  <= req_valid && req_write;
      lane_stb   <= req_valid ? stb_c : '0;
      lane_wdata <= req_valid ? wd_c : '0;
      if (!req_valid || req_write) rsp_rdata <= '0;
      else if (fault || bad_span)  rsp_rdata <= '1;
      else                         rsp_rdata <= rd_c;
      for (int i = 0; i < LANES; i++)
        lane_idx[i*IDX_W +: IDX_W] <= req_valid ? cls[i].idx : '0;
    end
  end
endmodule

// File: rtl/io_space_decoder_chk.sv
module io_space_decoder_chk
  import io_dec_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic                   req_super,
  input logic [1:0]             req_size,
  input logic [31:0]            req_addr,
  input logic                   early_fault,
  input logic                   bad_span,
  input logic                   rsp_valid,
  input logic                   rsp_berr,
  input logic [DATA_W-1:0]      rsp_rdata,
  input logic [LANES-1:0]       lane_stb,
  input logic [LANES*IDX_W-1:0] lane_idx
);
  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && lane_stb == '0);

  assert_below_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr[ADDR_W-1:0] < WIN_BASE) |=> rsp_berr && lane_stb == '0);

  assert_user_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_super |=> rsp_berr && lane_stb == '0);

  assert_span_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !early_fault && bad_span |=> !rsp_berr && lane_stb == '0);

  assert_span_reject_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !early_fault && bad_span |=> rsp_rdata == '1);

  assert_berr_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_berr |-> lane_stb == '0);

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == SZ_BYTE |=> lane_stb[LANES-1:1] == '0);

  assert_adjacent_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_stb[1] && lane_stb[0] |-> lane_idx[IDX_W +: IDX_W] != lane_idx[0 +: IDX_W]);
endmodule

bind io_space_decoder io_space_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_super   (req_super),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .early_fault (early_fault),
  .bad_span    (bad_span),
  .rsp_valid   (rsp_valid),
  .rsp_berr    (rsp_berr),
  .rsp_rdata   (rsp_rdata),
  .lane_stb    (lane_stb),
  .lane_idx    (lane_idx)
);

// File: tb/io_space_decoder_tb_top.sv
module io_space_decoder_tb_top;
  localparam int KH = 0, KR = 1, KF = 2, K0 = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b1;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0, lane_rdata = '0;
  logic        cfg_blitter_on = 1'b1, cfg_rtc_on = 1'b1, cfg_ext_bus = 1'b0;
  logic        rsp_valid, rsp_berr, rsp_write;
  logic [31:0] rsp_rdata, lane_wdata;
  logic [3:0]  lane_stb;
  logic [59:0] lane_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit mode_ref = 0;

  logic [31:0] pts [38] = '{
    32'hFF7FFF, 32'hFF8000, 32'hFF8005, 32'hFF803E, 32'hFF803F, 32'hFF8040,
    32'hFF81FF, 32'hFF8200, 32'hFF8201, 32'hFF823E, 32'hFF823F, 32'hFF8240,
    32'hFF827E, 32'hFF827F, 32'hFF8280, 32'hFF82FE, 32'hFF87FE, 32'hFF8800,
    32'hFF8802, 32'hFF8803, 32'hFF8804, 32'hFF8805, 32'hFF88FE, 32'hFF88FF,
    32'hFF8900, 32'hFF8A00, 32'hFF8A3E, 32'hFF8A40, 32'hFFFA00, 32'hFFFA01,
    32'hFFFC00, 32'hFFFC06, 32'hFFFC20, 32'hFFFC21, 32'hFFFC3E, 32'hFFFFFC,
    32'hFFFFFD, 32'hFFFFFF};

  always #5ns clk = ~clk;

  io_space_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_super(req_super),
    .req_wdata(req_wdata), .lane_rdata(lane_rdata),
    .cfg_blitter_on(cfg_blitter_on), .cfg_rtc_on(cfg_rtc_on), .cfg_ext_bus(cfg_ext_bus),
    .rsp_valid(rsp_valid), .rsp_berr(rsp_berr), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .lane_stb(lane_stb), .lane_idx(lane_idx),
    .lane_wdata(lane_wdata));

  task automatic chk(input string tag, input string field, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  // behavioural map of one byte address
  function automatic void ref_lane(input int unsigned a_in, input bit blit, input bit rtc,
                                   input bit ext, input bit mode, output int k, output int ix);
    int unsigned a, o;
    a = a_in; k = KH; ix = 0;
    if (a >= 'hFF8804 && a <= 'hFF88FF) begin
      if (ext) begin k = mode ? KH : KF; return; end
      a = a & 'hFFF803;
    end
    o = a - 'hFF8000;
    if (o <= 'h3F) begin k = KR; ix = o; end
    else if (o >= 'h200 && o <= 'h23F) begin if (o % 2 == 1) begin k = KR; ix = o; end end
    else if (o >= 'h240 && o <= 'h27F) begin k = KR; ix = o - o % 2; end
    else if (o >= 'h280 && o <= 'h2FF) k = K0;
    else if (o >= 'h800 && o <= 'h803) begin k = KR; ix = o - o % 2; end
    else if (o >= 'hA00 && o <= 'hA3F) begin if (blit) begin k = KR; ix = o - o % 2; end end
    else if (o >= 'h7A00 && o <= 'h7A3F) begin
      if (o % 2 == 1) begin k = KR; ix = o; end else k = KF;
    end
    else if (o >= 'h7C00 && o <= 'h7C07) begin k = KR; ix = o; end
    else if (o >= 'h7C21 && o <= 'h7C3F) begin
      if (!rtc) k = KF; else if (o % 2 == 1) begin k = KR; ix = o; end
    end
  endfunction

  task automatic access(input string tag, input bit wr, input logic [1:0] sz,
                        input logic [31:0] addr, input bit sup, input logic [31:0] wd);
    int n, holes, k, ix;
    int kd[4], ixs[4];
    int unsigned a;
    bit early, rej, berr;
    logic [7:0]  lb;
    logic [3:0]  es;
    logic [31:0] er, ew, lr, tmp;
    bit mode_hit, mode_val;
    a = addr & 32'h00FFFFFF;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    lr = 32'h5AC39E17 ^ {4{a[7:0]}};
    early = (a < 'hFF8000) || (wr && !sup);
    rej = !early && ((n == 2 && a > 'hFFFFFE) || (n == 4 && a > 'hFFFFFC));
    holes = 0; es = '0; er = '0; ew = '0;
    mode_hit = 0; mode_val = 0;
    tmp = wd;
    for (int i = n - 1; i >= 0; i--) begin
      ew[8*i +: 8] = tmp[7:0];
      tmp = tmp >> 8;
    end
    for (int i = 0; i < n; i++) begin
      ref_lane(a + i, cfg_blitter_on, cfg_rtc_on, cfg_ext_bus, mode_ref, k, ix);
      kd[i] = k; ixs[i] = ix;
      if (k == KH) holes++;
      lb = (k == KR) ? lr[8*i +: 8] : (k == K0) ? 8'h00 : 8'hFF;
      er = (er << 8) | 32'(lb);
      if (!early && !rej && k == KR && !(i > 0 && kd[i-1] == KR && ixs[i-1] == ix))
        es[i] = 1'b1;
    end
    berr = early || (!rej && holes == n);
    if (berr) es = '0;
    if (wr) er = '0;
    else if (berr || rej) er = 32'hFFFFFFFF;
    for (int i = 0; i < 4; i++)
      if (es[i] && ixs[i] == 7) begin mode_hit = 1; mode_val = ew[8*i + 5]; end

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
    req_super = sup; req_wdata = wd; lane_rdata = lr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "valid(R12)", 64'(rsp_valid), 64'd1);
    chk(tag, "write(R12)", 64'(rsp_write), 64'(wr));
    chk(tag, "berr(R4)", 64'(rsp_berr), 64'(berr));
    chk(tag, "rdata(R7)", 64'(rsp_rdata), 64'(er));
    chk(tag, "stb(R6)", 64'(lane_stb), 64'(es));
    chk(tag, "wdata(R12)", 64'(lane_wdata), 64'(ew));
    for (int i = 0; i < 4; i++)
      if (es[i]) chk(tag, "idx(R6)", 64'(lane_idx[15*i +: 15]), 64'(ixs[i]));
    if (wr && cfg_ext_bus && mode_hit) mode_ref = mode_val;
    @(negedge clk);
    chk(tag, "idle(R12)", {59'd0, rsp_valid, lane_stb}, 64'd0);
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 38; p++)
      for (int s = 0; s < 3; s++) begin
        access(tag, 1'b0, 2'(s), pts[p], 1'b1, 32'h0);
        access(tag, 1'b1, 2'(s), pts[p], 1'b1, 32'hC0DE5A00 ^ pts[p]);
      end
  endtask

  initial begin
    #(2_000_000ns);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R12 actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset", "outs", {rsp_valid, rsp_berr, rsp_write, lane_stb, rsp_rdata}, 64'd0);

    // directed cases, base config: no extended bus, all options present
    access("R1 below window", 1'b0, 2'd2, 32'h00FF7FFE, 1'b1, 0);
    access("R1 upper bits ignored", 1'b0, 2'd1, 32'h12FF8800, 1'b1, 0);
    access("R1 low address", 1'b1, 2'd0, 32'h00001000, 1'b1, 32'h55);
    access("R2 user write", 1'b1, 2'd0, 32'hFF8001, 1'b0, 32'h12);
    access("R2 user read", 1'b0, 2'd0, 32'hFF8001, 1'b0, 0);
    access("R3 long overrun", 1'b0, 2'd2, 32'hFFFFFD, 1'b1, 0);
    access("R3 word overrun write", 1'b1, 2'd1, 32'hFFFFFF, 1'b1, 32'hBEEF);
    access("R4 partial hole", 1'b0, 2'd1, 32'hFF8200, 1'b1, 0);
    access("R4 full hole word", 1'b0, 2'd1, 32'hFF8040, 1'b1, 0);
    access("R4 long one reg", 1'b0, 2'd2, 32'hFF81FE, 1'b1, 0);
    access("R5 void00", 1'b0, 2'd1, 32'hFF8280, 1'b1, 0);
    access("R5 voidFF mix", 1'b0, 2'd2, 32'hFFFA00, 1'b1, 0);
    access("R5 void write", 1'b1, 2'd1, 32'hFF8280, 1'b1, 32'h1234);
    access("R6 two sound regs", 1'b0, 2'd2, 32'hFF8800, 1'b1, 0);
    access("R6 palette long", 1'b1, 2'd2, 32'hFF8240, 1'b1, 32'hA1B2C3D4);
    access("R7 byte", 1'b0, 2'd0, 32'hFF8000, 1'b1, 0);
    access("R7 word", 1'b0, 2'd1, 32'hFF8000, 1'b1, 0);
    access("R7 long", 1'b0, 2'd2, 32'hFF8000, 1'b1, 0);
    access("R8 shadow word", 1'b0, 2'd1, 32'hFF8805, 1'b1, 0);
    access("R8 shadow write", 1'b1, 2'd0, 32'hFF88FE, 1'b1, 32'h77);
    sweep("R13 map sweep base");

    cfg_blitter_on = 1'b0; cfg_rtc_on = 1'b0;
    access("R9 blitter absent", 1'b0, 2'd1, 32'hFF8A00, 1'b1, 0);
    access("R10 clock absent", 1'b0, 2'd0, 32'hFFFC22, 1'b1, 0);
    access("R10 clock absent write", 1'b1, 2'd0, 32'hFFFC21, 1'b1, 32'h9);
    sweep("R9 R10 options absent sweep");
    cfg_blitter_on = 1'b1; cfg_rtc_on = 1'b1;
    access("R10 clock present even hole", 1'b0, 2'd0, 32'hFFFC22, 1'b1, 0);

    cfg_ext_bus = 1'b1;
    access("R11 mirror void at reset", 1'b0, 2'd0, 32'hFF8810, 1'b1, 0);
    access("R11 set mode", 1'b1, 2'd0, 32'hFF8007, 1'b1, 32'h20);
    access("R11 mirror hole", 1'b0, 2'd0, 32'hFF8810, 1'b1, 0);
    access("R11 user write no mode", 1'b1, 2'd0, 32'hFF8007, 1'b0, 32'h00);
    access("R11 mirror still hole", 1'b0, 2'd1, 32'hFF8880, 1'b1, 0);
    access("R11 clear via word", 1'b1, 2'd1, 32'hFF8006, 1'b1, 32'hFFDF);
    access("R11 mirror void again", 1'b0, 2'd1, 32'hFF8880, 1'b1, 0);
    sweep("R11 extended bus sweep");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule